// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Controller

This block is one general-purpose I/O port of sixteen pins sitting on a simple 32-bit register bus. Software configures each pin through a 4-bit field. The low two bits of the field choose between input and an output speed grade. The upper two bits choose floating, pulled, push-pull or open-drain behaviour. The block turns those fields and an output data register into per-pin pad controls: drive value, output enable, pull enable and pull direction. It also samples the pins into an input data register through a two-flop synchronizer.

Output bits can be written whole through the output data register. They can also be changed atomically through a write-only set/clear register, so no read-modify-write is needed. A clock-enable input stands in for the port's clock gate. While it is low the register interface is inert.

Top module: `gpio_port_top`

## Requirements
- R1: After reset both configuration registers read 0x44444444 (every pin floating input: mode 00, configuration 01), the output data register reads 0, and no pad is driven or pulled.
- R2: Pin n is configured by bits 4*(n mod 8)+3 down to 4*(n mod 8) of the low configuration register (byte offset 0x00) for n < 8, or of the high one (offset 0x04) for n >= 8. For example, pin 13 uses bits 23:20 at offset 0x04. Field bits 1:0 are the mode and bits 3:2 the configuration. Both registers read back what was written.
- R3: A mode of 01, 10 or 11 (11 being the fastest grade) makes the pin an output. With configuration bit 2 of the field clear (push-pull, e.g. configuration 00), the pad's output enable is 1 and its drive value equals the pin's output data bit.
- R4: An output pin with field bit 2 set (open-drain, e.g. configuration 01) drives 0 with output enable 1 when its output bit is 0. When its output bit is 1 it releases the pad: output enable 0 and drive value 0.
- R5: A pin in mode 00 never drives its pad. With configuration 10 (field value 0x8) its pull enable is 1 and its pull direction equals its output bit (1 = up). With any other input configuration both pull signals are 0.
- R6: The input data register (offset 0x08) returns, in bits 15:0, the pin levels sampled two clock edges earlier. Bits 31:16 read 0.
- R7: Writing the set/clear register (offset 0x10) drives output bit n to 1 for each 1 in data bit n (0 to 15), and to 0 for each 1 in data bit n+16. Bits written as 0 leave the output unchanged. If both bit n and bit n+16 are 1, the output bit becomes 1.
- R8: The set/clear register reads as 0. Writes to the input data register have no effect.
- R9: The output data register (offset 0x0C) is read/write in bits 15:0. Its bits 31:16 read 0.
- R10: While the clock-enable input is low, writes change no register and reads return 0.
- R11: Accesses to unmapped offsets (0x14 to 0x1C) or to an address with bits 1:0 non-zero read 0 and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Port clock enable; register access ignored when low |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address within the port |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| padIn | input | 16 | Pin levels from the pads |
| padOut | output | 16 | Drive value per pad |
| padOe | output | 16 | Output enable per pad |
| padPullEn | output | 16 | Pull resistor enable per pad |
| padPullUp | output | 16 | Pull direction per pad, 1 = up |

## Verification
The pad controls are tried with one pin configured in each of push-pull, open-drain and pulled-input, with their output bits both 0 and 1. This separates a swapped drive/enable for open-drain from a wrong mode decode. The set/clear register is exercised with set-only, clear-only and both-at-once patterns, which shows whether set really wins. A whole-register output write and a many-pin write check the mask arithmetic across bits. The input path is checked cycle by cycle after a pin change to pin down the two-edge latency. Writes with the clock enable low, at unmapped offsets and to read-only offsets are each followed by read-back of every register they could have touched.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CFG_LO,
    RD_CFG_HI,
    RD_IN,
    RD_OUT
  } rdSel_e;

  typedef struct packed {
    logic   wrCfgLo;
    logic   wrCfgHi;
    logic   wrOut;
    logic   wrSetClr;
    rdSel_e rdSel;
  } strobe_t;

  localparam logic [2:0] OFS_CFG_LO  = 3'd0;
  localparam logic [2:0] OFS_CFG_HI  = 3'd1;
  localparam logic [2:0] OFS_IN      = 3'd2;
  localparam logic [2:0] OFS_OUT     = 3'd3;
  localparam logic [2:0] OFS_SET_CLR = 3'd4;

  localparam logic [3:0] FIELD_RESET = 4'b0100;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clkEn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe
);

  logic       accessOk;
  logic [2:0] wordIdx;

  assign accessOk = busSel && clkEn && (busAddr[1:0] == 2'b00);
  assign wordIdx  = busAddr[4:2];

  always_comb begin
    strobe = '{wrCfgLo: 1'b0, wrCfgHi: 1'b0, wrOut: 1'b0,
               wrSetClr: 1'b0, rdSel: RD_NONE};
    if (accessOk) begin
      if (busWrite) begin
        unique case (wordIdx)
          OFS_CFG_LO:  strobe.wrCfgLo  = 1'b1;
          OFS_CFG_HI:  strobe.wrCfgHi  = 1'b1;
          OFS_OUT:     strobe.wrOut    = 1'b1;
          OFS_SET_CLR: strobe.wrSetClr = 1'b1;
          default: ;
        endcase
      end else begin
        unique case (wordIdx)
          OFS_CFG_LO: strobe.rdSel = RD_CFG_LO;
          OFS_CFG_HI: strobe.rdSel = RD_CFG_HI;
          OFS_IN:     strobe.rdSel = RD_IN;
          OFS_OUT:    strobe.rdSel = RD_OUT;
          default:    strobe.rdSel = RD_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic [3:0] field,
  input  logic       outBit,
  output logic       padOut,
  output logic       padOe,
  output logic       pullEn,
  output logic       pullUp
);

  logic [1:0] mode;
  logic [1:0] cnf;
  logic       isOutput;
  logic       openDrain;

  assign mode      = field[1:0];
  assign cnf       = field[3:2];
  assign isOutput  = (mode != 2'b00);
  assign openDrain = cnf[0];

  always_comb begin
    padOut = 1'b0;
    padOe  = 1'b0;
    pullEn = 1'b0;
    if (isOutput) begin
      if (openDrain) begin
        padOe  = ~outBit;
      end else begin
        padOe  = 1'b1;
        padOut = outBit;
      end
    end else begin
      pullEn = (cnf == 2'b10);
    end
  end

  assign pullUp = pullEn & outBit;

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padPullEn,
  output logic [PINS-1:0]   padPullUp,
  output logic [PINS-1:0]   outState,
  output logic [4*PINS-1:0] cfgState
);

  localparam int FIELD_W  = 4;
  localparam int CFG_W    = FIELD_W * PINS;
  localparam int REG_PINS = DATA_W / FIELD_W;
  localparam int PAD_W    = DATA_W - PINS;

  logic [CFG_W-1:0] cfgAll;
  logic [PINS-1:0]  outBits;
  logic [PINS-1:0]  syncA;
  logic [PINS-1:0]  syncB;
  logic [PINS-1:0]  setMask;
  logic [PINS-1:0]  clrMask;

  assign setMask = busWdata[PINS-1:0];
  assign clrMask = busWdata[2*PINS-1:PINS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAll <= {PINS{FIELD_RESET}};
    end else begin
      if (strobe.wrCfgLo) cfgAll[DATA_W-1:0]     <= busWdata;
      if (strobe.wrCfgHi) cfgAll[CFG_W-1:DATA_W] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBits <= '0;
    end else if (strobe.wrOut) begin
      outBits <= busWdata[PINS-1:0];
    end else if (strobe.wrSetClr) begin
      outBits <= (outBits & ~clrMask) | setMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_CFG_LO: busRdata = cfgAll[DATA_W-1:0];
      RD_CFG_HI: busRdata = cfgAll[CFG_W-1:DATA_W];
      RD_IN:     busRdata = {{PAD_W{1'b0}}, syncB};
      RD_OUT:    busRdata = {{PAD_W{1'b0}}, outBits};
      default:   busRdata = '0;
    endcase
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    gpio_pin_cell u_cell (
      .field  (cfgAll[FIELD_W*p +: FIELD_W]),
      .outBit (outBits[p]),
      .padOut (padOut[p]),
      .padOe  (padOe[p]),
      .pullEn (padPullEn[p]),
      .pullUp (padPullUp[p])
    );
  end

  if (REG_PINS * 2 != PINS) begin : g_bad_cfg
    initial $error("PINS must fill exactly two configuration registers");
  end

  assign outState = outBits;
  assign cfgState = cfgAll;

endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padPullEn,
  output logic [PINS-1:0]   padPullUp
);

  strobe_t            strobe;
  logic [PINS-1:0]    outState;
  logic [4*PINS-1:0]  cfgState;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clkEn    (clkEn),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  gpio_port_dp #(.PINS(PINS), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullEn (padPullEn),
    .padPullUp (padPullUp),
    .outState  (outState),
    .cfgState  (cfgState)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PINS   = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [PINS-1:0]   padIn,
  input logic [PINS-1:0]   padOut,
  input logic [PINS-1:0]   padOe,
  input logic [PINS-1:0]   outState,
  input logic [4*PINS-1:0] cfgState
);

  logic [1:0] edgesUp;
  logic       setClrWr;
  logic       inRead;
  logic       setClrRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                edgesUp <= 2'd0;
    else if (edgesUp != 2'd2) edgesUp <= edgesUp + 2'd1;
  end

  assign setClrWr   = busSel && busWrite && clkEn && (busAddr == ADDR_W'(16));
  assign inRead     = busSel && !busWrite && clkEn && (busAddr == ADDR_W'(8));
  assign setClrRead = busSel && !busWrite && (busAddr == ADDR_W'(16));

  // R7: every set bit is 1 after the write
  a_r7_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    setClrWr |=> ((outState & $past(busWdata[PINS-1:0])) == $past(busWdata[PINS-1:0])));

  // R7: clear-only bits are 0 after the write
  a_r7_clr_bits: assert property (@(posedge clk) disable iff (!rstN)
    setClrWr |=> ((outState & $past(busWdata[2*PINS-1:PINS]) & ~$past(busWdata[PINS-1:0])) == '0));

  // R10: gated port holds its state
  a_r10_gated_hold: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(outState) && $stable(cfgState)));

  // R10: gated reads return zero
  a_r10_gated_read: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> (busRdata == '0));

  // R8: set/clear register reads zero
  a_r8_setclr_read: assert property (@(posedge clk) disable iff (!rstN)
    setClrRead |-> (busRdata == '0));

  // R6: input data lags the pins by two edges
  a_r6_sync_lag: assert property (@(posedge clk) disable iff (!rstN)
    (inRead && edgesUp == 2'd2) |-> (busRdata == {{(DATA_W-PINS){1'b0}}, $past(padIn, 2)}));

  for (genvar p = 0; p < PINS; p++) begin : g_pinchk
    // R5: input-mode pins never drive
    a_r5_input_quiet: assert property (@(posedge clk) disable iff (!rstN)
      (cfgState[4*p +: 2] == 2'b00) |-> !padOe[p]);
    // R4: open-drain outputs never drive high
    a_r4_od_low_only: assert property (@(posedge clk) disable iff (!rstN)
      ((cfgState[4*p +: 2] != 2'b00) && cfgState[4*p+2]) |-> !padOut[p]);
  end

endmodule

bind gpio_port_top gpio_port_chk #(.PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkEn    (clkEn),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .padIn    (padIn),
  .padOut   (padOut),
  .padOe    (padOe),
  .outState (outState),
  .cfgState (cfgState)
);

// File: tb/sim_gpio_port_top.sv
module sim_gpio_port_top;

  localparam int CLK_PERIOD = 10;

  localparam int K_RD   = 0;
  localparam int K_OUT  = 1;
  localparam int K_OE   = 2;
  localparam int K_PEN  = 3;
  localparam int K_PUP  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b1;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] padIn = '0;
  logic [15:0] padOut, padOe, padPullEn, padPullUp;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];
  int    applied = 0;
  int    misses  = 0;
  bit    done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_top u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn), .padPullUp(padPullUp)
  );

  // monitor: compares queued expectations a quarter period after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (expQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        case (it.kind)
          K_RD:    act = busRdata;
          K_OUT:   act = {16'h0, padOut};
          K_OE:    act = {16'h0, padOe};
          K_PEN:   act = {16'h0, padPullEn};
          default: act = {16'h0, padPullUp};
        endcase
        applied++;
        if (act !== it.exp) begin
          misses++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    push(K_RD, exp, tag);
  endtask

  task automatic pads(input logic [15:0] o, input logic [15:0] oe,
                      input logic [15:0] pe, input logic [15:0] pu, input string tag);
    @(negedge clk);
    busSel = 1'b0;
    push(K_OUT, {16'h0, o},  {tag, " padOut"});
    push(K_OE,  {16'h0, oe}, {tag, " padOe"});
    push(K_PEN, {16'h0, pe}, {tag, " padPullEn"});
    push(K_PUP, {16'h0, pu}, {tag, " padPullUp"});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(5'h00, 32'h4444_4444, "R1 cfgLo reset");
    rd(5'h04, 32'h4444_4444, "R1 cfgHi reset");
    rd(5'h0C, 32'h0, "R1 outData reset");
    pads(16'h0, 16'h0, 16'h0, 16'h0, "R1 pads idle");

    // R2 pin 13 push-pull fastest output at cfgHi[23:20]
    wr(5'h04, 32'h4434_4444);
    rd(5'h04, 32'h4434_4444, "R2 cfgHi readback");
    // R3/R7 set then clear bit 13
    wr(5'h10, 32'h0000_2000);
    pads(16'h2000, 16'h2000, 16'h0, 16'h0, "R3 pp high");
    wr(5'h10, 32'h2000_0000);
    pads(16'h0000, 16'h2000, 16'h0, 16'h0, "R7 clear bit13");
    // R7 set wins over clear
    wr(5'h10, 32'h2000_2000);
    rd(5'h0C, 32'h0000_2000, "R7 set wins");
    rd(5'h10, 32'h0, "R8 setclr reads 0");

    // R4 pin 0 open-drain
    wr(5'h00, 32'h4444_4447);
    rd(5'h00, 32'h4444_4447, "R2 cfgLo readback");
    pads(16'h2000, 16'h2001, 16'h0, 16'h0, "R4 od low");
    wr(5'h10, 32'h0000_0001);
    pads(16'h2000, 16'h2000, 16'h0, 16'h0, "R4 od released");

    // R5 pin 2 pulled input
    wr(5'h00, 32'h4444_4847);
    pads(16'h2000, 16'h2000, 16'h0004, 16'h0000, "R5 pull down");
    wr(5'h10, 32'h0000_0004);
    pads(16'h2000, 16'h2000, 16'h0004, 16'h0004, "R5 pull up");

    // R9 whole-register output write
    wr(5'h0C, 32'hFFFF_0001);
    rd(5'h0C, 32'h0000_0001, "R9 outData upper zero");
    pads(16'h0000, 16'h2000, 16'h0004, 16'h0000, "R9 pads after out write");

    // R6 synchronizer latency
    @(negedge clk);
    padIn = 16'hA5C3;
    busSel = 1'b1; busWrite = 1'b0; busAddr = 5'h08;
    push(K_RD, 32'h0, "R6 zero edges");
    rd(5'h08, 32'h0, "R6 one edge");
    rd(5'h08, 32'h0000_A5C3, "R6 two edges");
    wr(5'h08, 32'h0000_1234);
    rd(5'h08, 32'h0000_A5C3, "R8 inData write ignored");

    // R10 gated port
    @(negedge clk);
    clkEn = 1'b0;
    busSel = 1'b0;
    wr(5'h10, 32'h0000_0002);
    wr(5'h00, 32'h0000_0000);
    rd(5'h00, 32'h0, "R10 gated read zero");
    @(negedge clk);
    busSel = 1'b0;
    clkEn = 1'b1;
    rd(5'h0C, 32'h0000_0001, "R10 out unchanged");
    rd(5'h00, 32'h4444_4847, "R10 cfgLo unchanged");

    // R11 unmapped and misaligned
    rd(5'h14, 32'h0, "R11 unmapped read");
    rd(5'h01, 32'h0, "R11 misaligned read");
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h02, 32'hFFFF_FFFF);
    rd(5'h00, 32'h4444_4847, "R11 cfgLo unchanged");
    rd(5'h04, 32'h4434_4444, "R11 cfgHi unchanged");
    rd(5'h0C, 32'h0000_0001, "R11 out unchanged");

    // R3/R7 many pins at once
    wr(5'h00, 32'h3333_3333);
    wr(5'h10, 32'h0001_00F0);
    rd(5'h0C, 32'h0000_00F0, "R7 multi set/clear");
    pads(16'h00F0, 16'h20FF, 16'h0, 16'h0, "R3 multi pp");

    @(negedge clk);
    busSel = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule